// File: doc/BRIEF.md
# Channel Buffer Pointer Tracker

This block keeps the buffer pointers for a set of logical channels in a streaming-bus DMA engine. Each channel owns a current buffer in system memory, described by a 16-bit lower-half current pointer and a 16-bit lower-half final pointer. It may also hold one pending next buffer, given as a start and an end pointer. The transfer engine reports quadlet completions and packet completions for one channel per cycle. For each completed quadlet the tracker emits the full 32-bit memory address of that quadlet and steps the current pointer forward by four bytes.

The tracker also decides when the current buffer is finished. Synchronous and isochronous channels finish on a quadlet. Asynchronous and control channels finish on a packet, so a packet in flight may run past the final pointer. When a buffer finishes, the pending next buffer takes its place, and the channel reports buffer-done and buffer-swap pulses. If no next buffer is pending, the channel goes starved and ignores traffic until software supplies one.

The upper 16 address bits come from one of eight base values. The choice depends on the channel's type and on its direction (receive or transmit).

Top module: `chbuf_tracker`

## Requirements
- R1: After synchronous reset, no channel holds a current or next buffer, and `out_valid`, `buf_done`, `buf_swap` and `starved` are all zero.
- R2: A quadlet-done event (`ev_valid` and `ev_quad`) on a channel that holds a current buffer produces, one cycle later, `out_valid`=1 with `out_ch` equal to that channel and `out_addr` = {upper half, current pointer before the step}. Events on channels without a current buffer produce no output.
- R3: Every loaded current pointer has bits [1:0] equal to 00, and each accepted quadlet adds 4 to it.
- R4: On promotion, bits [15:2] of the final pointer come from the next buffer's end. Bits [1:0] are also copied from the end when the channel type is isochronous (code 3); for every other type they are 00.
- R5: On synchronous (code 0) and isochronous (code 3) channels, a quadlet-done accepted while current pointer >= final pointer is the last quadlet of the buffer. `buf_done[ch]` pulses one cycle later, and packet-done strobes have no effect on these types.
- R6: On asynchronous (code 1) and control (code 2) channels, quadlets keep advancing past the final pointer. The buffer ends at the first packet-done that arrives once an accepted quadlet has had current pointer >= final pointer; this includes a quadlet in the same cycle as the packet-done.
- R7: The upper half is `upper_bases[idx*16 +: 16]` with idx = dir*4 + type. Here dir=1 means transmit, and the type codes are 0 synchronous, 1 asynchronous, 2 control and 3 isochronous.
- R8: When a buffer ends with a next buffer pending, `buf_swap[ch]` pulses in the same cycle as `buf_done[ch]` and the next buffer becomes current. A channel without a current buffer promotes a pending next buffer one cycle after the cycle in which it was written. A next-buffer write in the same cycle as an end is held as pending.
- R9: When a buffer ends with no next buffer pending, `starved[ch]` rises and the channel ignores quadlets. The next promotion clears `starved[ch]`.
- R10: A next buffer whose start equals its end gives single-packet buffering. A synchronous channel finishes after one quadlet. An asynchronous or control channel finishes at the first packet-done that arrives with or after its first quadlet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_type_cfg | input | 2*NUM_CH | Per-channel type code, channel n in bits [2n+1:2n] |
| ch_dir_cfg | input | NUM_CH | Per-channel direction, 1 = transmit |
| upper_bases | input | 8*HI_W | Eight upper-half base values, index dir*4+type |
| ev_valid | input | 1 | Transfer event present this cycle |
| ev_ch | input | CHW | Channel of the event |
| ev_quad | input | 1 | A quadlet completed |
| ev_pkt | input | 1 | A packet completed |
| nb_wr | input | 1 | Write a pending next buffer |
| nb_ch | input | CHW | Channel receiving the next buffer |
| nb_start | input | LO_W | Next buffer start pointer (lower half) |
| nb_end | input | LO_W | Next buffer end pointer (lower half) |
| out_valid | output | 1 | Registered: a quadlet address is presented |
| out_ch | output | CHW | Channel of the presented address |
| out_addr | output | HI_W+LO_W | Full memory address of the completed quadlet |
| buf_done | output | NUM_CH | One-cycle pulse per channel when its buffer finishes |
| buf_swap | output | NUM_CH | One-cycle pulse per channel when a next buffer becomes current |
| starved | output | NUM_CH | Channel finished a buffer with no next buffer pending |

## Verification
The hardest case to reach from the ports is an asynchronous or control channel that has crossed its final pointer but is still inside a packet. The tracker has to keep stepping past the final pointer and then end exactly at the packet strobe, sometimes with a next-buffer write landing in that same cycle. Directed sequences first drive quadlets past the final pointer on such a channel, then issue the packet strobe with a next buffer pending. A seeded random phase then mixes short buffers, frequent next-buffer writes and sparse packet strobes, so that end, starvation and write collisions occur many times on every type.

// File: rtl/chbuf_pkg.sv
package chbuf_pkg;
  typedef enum logic [1:0] {
    CT_SYNC  = 2'd0,
    CT_ASYNC = 2'd1,
    CT_CTRL  = 2'd2,
    CT_ISO   = 2'd3
  } chan_kind_e;

  localparam int N_BASE = 8;

  function automatic logic pkt_granular(input logic [1:0] kind);
    return (kind == CT_ASYNC) || (kind == CT_CTRL);
  endfunction

  function automatic logic is_iso(input logic [1:0] kind);
    return kind == CT_ISO;
  endfunction
endpackage

// File: rtl/chbuf_chan.sv
module chbuf_chan
  import chbuf_pkg::*;
#(
  parameter int LO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      kind,
  input  logic            quad,
  input  logic            pkt,
  input  logic            nb_wr,
  input  logic [LO_W-1:0] nb_start,
  input  logic [LO_W-1:0] nb_end,
  output logic [LO_W-1:0] cur_addr,
  output logic            cur_valid,
  output logic            starved,
  output logic            done_pulse,
  output logic            swap_pulse
);
  logic [LO_W-1:0] fin_addr;
  logic [LO_W-1:0] nxt_start;
  logic [LO_W-1:0] nxt_end;
  logic            nxt_valid;
  logic            reached;

  logic            at_fin;
  logic            end_now;
  logic [LO_W-1:0] load_cur;
  logic [LO_W-1:0] load_fin;

  always_comb begin
    at_fin   = cur_addr >= fin_addr;
    if (pkt_granular(kind))
      end_now = cur_valid && pkt && (reached || (quad && at_fin));
    else
      end_now = cur_valid && quad && at_fin;
    load_cur = {nxt_start[LO_W-1:2], 2'b00};
    load_fin = {nxt_end[LO_W-1:2], is_iso(kind) ? nxt_end[1:0] : 2'b00};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr   <= '0;
      fin_addr   <= '0;
      cur_valid  <= 1'b0;
      nxt_start  <= '0;
      nxt_end    <= '0;
      nxt_valid  <= 1'b0;
      reached    <= 1'b0;
      starved    <= 1'b0;
      done_pulse <= 1'b0;
      swap_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      swap_pulse <= 1'b0;
      if (cur_valid) begin
        if (end_now) begin
          done_pulse <= 1'b1;
          reached    <= 1'b0;
          if (nxt_valid) begin
            cur_addr   <= load_cur;
            fin_addr   <= load_fin;
            nxt_valid  <= 1'b0;
            swap_pulse <= 1'b1;
          end else begin
            cur_valid <= 1'b0;
            starved   <= 1'b1;
          end
        end else if (quad) begin
          cur_addr <= cur_addr + LO_W'(4);
          if (at_fin) reached <= 1'b1;
        end
      end else if (nxt_valid) begin
        cur_addr   <= load_cur;
        fin_addr   <= load_fin;
        cur_valid  <= 1'b1;
        nxt_valid  <= 1'b0;
        starved    <= 1'b0;
        reached    <= 1'b0;
        swap_pulse <= 1'b1;
      end
      if (nb_wr) begin
        nxt_start <= nb_start;
        nxt_end   <= nb_end;
        nxt_valid <= 1'b1;
      end
    end
  end

  AST_CUR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    cur_valid |-> (cur_addr[1:0] == 2'b00)); // R3

  AST_FIN_ALIGNED_NON_ISO: assert property (@(posedge clk) disable iff (rst)
    (cur_valid && !is_iso(kind)) |-> (fin_addr[1:0] == 2'b00)); // R4

  AST_STARVED_NO_CURRENT: assert property (@(posedge clk) disable iff (rst)
    starved |-> !cur_valid); // R9

  AST_SWAP_GIVES_CURRENT: assert property (@(posedge clk) disable iff (rst)
    swap_pulse |-> (cur_valid && !starved)); // R8

  AST_SWAP_CONSUMES_NEXT: assert property (@(posedge clk) disable iff (rst)
    (swap_pulse && !$past(nb_wr)) |-> !nxt_valid); // R8
endmodule

// File: rtl/chbuf_base_sel.sv
module chbuf_base_sel
  import chbuf_pkg::*;
#(
  parameter int HI_W = 16
) (
  input  logic [N_BASE*HI_W-1:0] upper_bases,
  input  logic [1:0]             kind,
  input  logic                   dir,
  output logic [HI_W-1:0]        base
);
  localparam int IDX_W = $clog2(N_BASE);

  logic [HI_W-1:0]  tbl [N_BASE];
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < N_BASE; g++) begin : g_unpack
    assign tbl[g] = upper_bases[g*HI_W +: HI_W];
  end

  assign idx  = {dir, kind};
  assign base = tbl[idx];
endmodule

// File: rtl/chbuf_addr_out.sv
module chbuf_addr_out #(
  parameter int CHW  = 4,
  parameter int LO_W = 16,
  parameter int HI_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [CHW-1:0]       ch,
  input  logic [HI_W-1:0]      hi,
  input  logic [LO_W-1:0]      lo,
  output logic                 out_valid,
  output logic [CHW-1:0]       out_ch,
  output logic [HI_W+LO_W-1:0] out_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_ch   <= ch;
        out_addr <= {hi, lo};
      end
    end
  end
endmodule

// File: rtl/chbuf_tracker.sv
module chbuf_tracker
  import chbuf_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int LO_W   = 16,
  parameter int HI_W   = 16,
  localparam int CHW   = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*NUM_CH-1:0]    ch_type_cfg,
  input  logic [NUM_CH-1:0]      ch_dir_cfg,
  input  logic [N_BASE*HI_W-1:0] upper_bases,
  input  logic                   ev_valid,
  input  logic [CHW-1:0]         ev_ch,
  input  logic                   ev_quad,
  input  logic                   ev_pkt,
  input  logic                   nb_wr,
  input  logic [CHW-1:0]         nb_ch,
  input  logic [LO_W-1:0]        nb_start,
  input  logic [LO_W-1:0]        nb_end,
  output logic                   out_valid,
  output logic [CHW-1:0]         out_ch,
  output logic [HI_W+LO_W-1:0]   out_addr,
  output logic [NUM_CH-1:0]      buf_done,
  output logic [NUM_CH-1:0]      buf_swap,
  output logic [NUM_CH-1:0]      starved
);
  logic [LO_W-1:0] cur_lo [NUM_CH];
  logic [NUM_CH-1:0] cur_v;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic hit;
    assign hit = ev_valid && (ev_ch == CHW'(g));

    chbuf_chan #(.LO_W(LO_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .kind       (ch_type_cfg[2*g +: 2]),
      .quad       (hit && ev_quad),
      .pkt        (hit && ev_pkt),
      .nb_wr      (nb_wr && (nb_ch == CHW'(g))),
      .nb_start   (nb_start),
      .nb_end     (nb_end),
      .cur_addr   (cur_lo[g]),
      .cur_valid  (cur_v[g]),
      .starved    (starved[g]),
      .done_pulse (buf_done[g]),
      .swap_pulse (buf_swap[g])
    );
  end

  logic [1:0]      ev_kind;
  logic            ev_dir;
  logic [HI_W-1:0] ev_hi;
  logic            fire;

  assign ev_kind = ch_type_cfg[2*ev_ch +: 2];
  assign ev_dir  = ch_dir_cfg[ev_ch];
  assign fire    = ev_valid && ev_quad && cur_v[ev_ch];

  chbuf_base_sel #(.HI_W(HI_W)) u_base (
    .upper_bases (upper_bases),
    .kind        (ev_kind),
    .dir         (ev_dir),
    .base        (ev_hi)
  );

  chbuf_addr_out #(.CHW(CHW), .LO_W(LO_W), .HI_W(HI_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .ch        (ev_ch),
    .hi        (ev_hi),
    .lo        (cur_lo[ev_ch]),
    .out_valid (out_valid),
    .out_ch    (out_ch),
    .out_addr  (out_addr)
  );

  AST_ADDR_NEEDS_QUAD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(ev_valid && ev_quad)); // R2

  AST_ADDR_LOW_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_addr[1:0] == 2'b00)); // R3

  AST_STARVED_NO_TRAFFIC: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && starved[ev_ch]) |=> !out_valid); // R9
endmodule

// File: tb/tb_chbuf_tracker.sv
`timescale 1ns/1ps
module tb_chbuf_tracker;
  localparam int NUM_CH = 16;
  localparam int LO_W   = 16;
  localparam int HI_W   = 16;
  localparam int CHW    = $clog2(NUM_CH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*NUM_CH-1:0] ch_type_cfg = '0;
  logic [NUM_CH-1:0]   ch_dir_cfg  = '0;
  logic [8*HI_W-1:0]   upper_bases = '0;
  logic ev_valid = 1'b0, ev_quad = 1'b0, ev_pkt = 1'b0, nb_wr = 1'b0;
  logic [CHW-1:0] ev_ch = '0, nb_ch = '0;
  logic [LO_W-1:0] nb_start = '0, nb_end = '0;
  logic out_valid;
  logic [CHW-1:0] out_ch;
  logic [HI_W+LO_W-1:0] out_addr;
  logic [NUM_CH-1:0] buf_done, buf_swap, starved;

  always #4 clk = ~clk;

  chbuf_tracker #(.NUM_CH(NUM_CH), .LO_W(LO_W), .HI_W(HI_W)) dut (
    .clk(clk), .rst(rst), .ch_type_cfg(ch_type_cfg), .ch_dir_cfg(ch_dir_cfg),
    .upper_bases(upper_bases), .ev_valid(ev_valid), .ev_ch(ev_ch),
    .ev_quad(ev_quad), .ev_pkt(ev_pkt), .nb_wr(nb_wr), .nb_ch(nb_ch),
    .nb_start(nb_start), .nb_end(nb_end), .out_valid(out_valid),
    .out_ch(out_ch), .out_addr(out_addr), .buf_done(buf_done),
    .buf_swap(buf_swap), .starved(starved));

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  logic [15:0] m_cur [NUM_CH];
  logic [15:0] m_fin [NUM_CH];
  logic [15:0] m_ns  [NUM_CH];
  logic [15:0] m_ne  [NUM_CH];
  logic        m_cv  [NUM_CH];
  logic        m_nv  [NUM_CH];
  logic        m_rch [NUM_CH];
  logic [NUM_CH-1:0] m_st;
  logic [15:0] m_base [8];
  logic        e_ov;
  logic [CHW-1:0] e_och;
  logic [31:0] e_oa;
  logic [NUM_CH-1:0] e_done, e_swap;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] kind_of(input int c);
    return ch_type_cfg[2*c +: 2];
  endfunction

  function automatic logic [15:0] upper_of(input int c);
    return m_base[{ch_dir_cfg[c], kind_of(c)}];
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NUM_CH; c++) begin
      m_cur[c] = '0; m_fin[c] = '0; m_ns[c] = '0; m_ne[c] = '0;
      m_cv[c] = 0; m_nv[c] = 0; m_rch[c] = 0;
    end
    m_st = '0;
  endtask

  task automatic promote(input int c);
    m_cur[c] = {m_ns[c][15:2], 2'b00};
    m_fin[c] = {m_ne[c][15:2], (kind_of(c) == 2'd3) ? m_ne[c][1:0] : 2'b00};
    m_rch[c] = 0;
    m_nv[c]  = 0;
  endtask

  task automatic model_step();
    e_ov  = ev_valid && ev_quad && m_cv[ev_ch];
    e_och = ev_ch;
    e_oa  = {upper_of(int'(ev_ch)), m_cur[ev_ch]};
    e_done = '0; e_swap = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      bit q, p, at, pg, en;
      q  = ev_valid && ev_quad && (int'(ev_ch) == c);
      p  = ev_valid && ev_pkt && (int'(ev_ch) == c);
      at = m_cur[c] >= m_fin[c];
      pg = (kind_of(c) == 2'd1) || (kind_of(c) == 2'd2);
      if (m_cv[c]) begin
        en = pg ? (p && (m_rch[c] || (q && at))) : (q && at);
        if (en) begin
          e_done[c] = 1;
          m_rch[c] = 0;
          if (m_nv[c]) begin promote(c); e_swap[c] = 1; end
          else begin m_cv[c] = 0; m_st[c] = 1; end
        end else if (q) begin
          m_cur[c] = m_cur[c] + 16'd4;
          if (at) m_rch[c] = 1;
        end
      end else if (m_nv[c]) begin
        promote(c); m_cv[c] = 1; m_st[c] = 0; e_swap[c] = 1;
      end
      if (nb_wr && int'(nb_ch) == c) begin
        m_ns[c] = nb_start; m_ne[c] = nb_end; m_nv[c] = 1;
      end
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(out_valid == e_ov, "R2 out_valid", 32'(out_valid), 32'(e_ov));
    if (e_ov) begin
      check(out_addr == e_oa, "R2/R7 out_addr", out_addr, e_oa);
      check(out_ch == e_och, "R2 out_ch", 32'(out_ch), 32'(e_och));
    end
    check(buf_done == e_done, "R5/R6 buf_done", 32'(buf_done), 32'(e_done));
    check(buf_swap == e_swap, "R8 buf_swap", 32'(buf_swap), 32'(e_swap));
    check(starved == m_st, "R9 starved", 32'(starved), 32'(m_st));
    ev_valid = 0; ev_quad = 0; ev_pkt = 0; nb_wr = 0;
  endtask

  task automatic quad(input int c, input bit with_pkt);
    ev_valid = 1; ev_ch = CHW'(c); ev_quad = 1; ev_pkt = with_pkt;
    cycle();
  endtask

  task automatic pkt_only(input int c);
    ev_valid = 1; ev_ch = CHW'(c); ev_quad = 0; ev_pkt = 1;
    cycle();
  endtask

  task automatic next_buf(input int c, input logic [15:0] s, input logic [15:0] e);
    nb_wr = 1; nb_ch = CHW'(c); nb_start = s; nb_end = e;
    cycle();
  endtask

  task automatic do_reset();
    for (int i = 0; i < 8; i++) upper_bases[i*HI_W +: HI_W] = m_base[i];
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    #(8ns * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) m_base[i] = 16'hA000 + 16'(i * 16'h111);
    // ch0 sync rx, ch1 async tx, ch2 iso rx, ch3 control tx, ch4 sync tx
    ch_type_cfg = '0; ch_dir_cfg = '0;
    ch_type_cfg[2*1 +: 2] = 2'd1; ch_dir_cfg[1] = 1;
    ch_type_cfg[2*2 +: 2] = 2'd3;
    ch_type_cfg[2*3 +: 2] = 2'd2; ch_dir_cfg[3] = 1;
    ch_dir_cfg[4] = 1;
    do_reset();
    check(!out_valid && buf_done == 0 && buf_swap == 0 && starved == 0,
          "R1 reset outputs", {out_valid, buf_done, buf_swap[14:0]}, 32'h0);

    quad(0, 0);  // no buffer yet: no output (R2)
    check(!out_valid, "R2 no buffer no output", 32'(out_valid), 0);

    // sync channel 0: 0x10..0x18
    next_buf(0, 16'h0010, 16'h0018);
    cycle();
    check(buf_swap[0], "R8 idle promotion one cycle after write", 32'(buf_swap), 1);
    quad(0, 0);
    check(out_addr == 32'hA000_0010, "R7 base idx 0", out_addr, 32'hA000_0010);
    quad(0, 0);
    check(out_addr == 32'hA000_0014, "R3 step by 4", out_addr, 32'hA000_0014);
    quad(0, 1);
    check(buf_done[0] && starved[0], "R5 sync end and R9 starve", {buf_done[0], starved[0]}, 2'b11);
    quad(0, 0);
    check(!out_valid, "R9 starved ignores quadlet", 32'(out_valid), 0);
    next_buf(0, 16'h0042, 16'h0042);
    cycle();
    check(!starved[0], "R9 starved cleared", 32'(starved), 0);
    quad(0, 0);
    check(buf_done[0] && out_addr == 32'hA000_0040, "R10 single quadlet sync, R3 aligned", out_addr, 32'hA000_0040);

    // async channel 1 (tx, idx 5)
    next_buf(1, 16'h0100, 16'h0104);
    cycle();
    next_buf(1, 16'h0200, 16'h0200);
    quad(1, 0); quad(1, 0); quad(1, 0);
    check(out_addr == 32'hA555_0108 && buf_done[1] == 0, "R6 runs past final", out_addr, 32'hA555_0108);
    pkt_only(1);
    check(buf_done[1] && buf_swap[1], "R6 end at packet, R8 swap with done", {buf_done[1], buf_swap[1]}, 2'b11);
    quad(1, 1);
    check(buf_done[1] && out_addr == 32'hA555_0200, "R10 single packet async", out_addr, 32'hA555_0200);

    // iso channel 2 (idx 3): final keeps low bits 0x0107
    next_buf(2, 16'h0100, 16'h0107);
    cycle();
    quad(2, 1);
    quad(2, 0);
    check(buf_done[2] == 0, "R5 pkt ignored on iso / R4 not yet", 32'(buf_done), 0);
    quad(2, 0);
    check(buf_done[2] && out_addr == 32'hA333_0108, "R4 iso final low bits", out_addr, 32'hA333_0108);

    // sync tx channel 4 (idx 4): final low bits cleared
    next_buf(4, 16'h0100, 16'h0107);
    cycle();
    quad(4, 0);
    quad(4, 0);
    check(buf_done[4] && out_addr == 32'hA444_0104, "R4 non-iso final cleared", out_addr, 32'hA444_0104);

    // control channel 3: end and next write collide
    next_buf(3, 16'h0300, 16'h0300);
    cycle();
    nb_wr = 1; nb_ch = 3; nb_start = 16'h0400; nb_end = 16'h0404;
    quad(3, 1);
    check(buf_done[3] && !buf_swap[3], "R8 collision write held", {buf_done[3], buf_swap[3]}, 2'b10);
    cycle();
    check(buf_swap[3], "R8 held write promotes", 32'(buf_swap), 32'h8);

    // random phase
    for (int c = 0; c < NUM_CH; c++) begin
      ch_type_cfg[2*c +: 2] = 2'($urandom % 4);
      ch_dir_cfg[c] = 1'($urandom % 2);
    end
    for (int i = 0; i < 8; i++) m_base[i] = 16'($urandom);
    do_reset();
    for (int n = 0; n < 6000; n++) begin
      ev_valid = ($urandom % 4) != 0;
      ev_ch    = CHW'($urandom % NUM_CH);
      ev_quad  = ($urandom % 4) != 0;
      ev_pkt   = ($urandom % 5) == 0;
      nb_wr    = ($urandom % 6) == 0;
      nb_ch    = CHW'($urandom % NUM_CH);
      nb_start = 16'(($urandom % 64) * 4 + ($urandom % 4));
      nb_end   = nb_start + 16'($urandom % 40);
      cycle();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule